// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block reads a matrix of up to six drive lines by five sense inputs, thirty keys in all. While no key is down, the drive lines sit at fixed idle levels. The sense inputs are synchronized, and the block stays idle until one of them reads high. That high starts a pair of back-to-back scans. Each scan raises one drive line at a time and latches the sense row seen under it. A key pattern is accepted only when both scans of a pair see the same nonzero pattern. The block then loads the pattern into a key buffer and raises an active-low read request towards the serial interface.

When the serial interface reports that the buffer has been read, the request clears and a fresh scan pair begins. This repeats for as long as any key is held. An agreeing all-zero pair returns the block to idle.

A two-bit sleep code chooses which drive lines stay high at idle. Only a key on a high line can wake the block. A two-bit share code hands the first one or two drive lines over to other use. Those lines are then never driven, and their key bits always read 0. A chip-enable-high input masks the request while a transfer is in progress.

Top module: `keymat_scanner`

## Requirements
- R1: Bit index (r-1)*5+(c-1) of `key_data` reports the key between drive line r (1..6, `drive_out` bit r-1) and sense input c (1..5, `sense_in` bit c-1).
- R2: A scan lasts 384 cycles and is split into six 64-cycle slots. A pattern is accepted only when two consecutive scans agree. A disagreement restarts the pair. An agreeing all-zero pair returns to idle with no request.
- R3: `req_n` falls no earlier than 800 cycles after the scan pair that produced the pattern began. A press released within about 300 cycles is never reported.
- R4: Once `req_n` is low it stays low until a `rd_done` pulse. It is high on the next cycle. A new scan pair then starts, so held keys raise a new request and released keys raise none.
- R5: At idle, `drive_out` depends on `sleep_code`. Codes 00 and 11 drive all lines high. Code 01 drives only line 6 high. Code 10 drives lines 5 and 6 high. All other lines are low. A key on a low line does not start a scan.
- R6: `share_code` 01 hands line 1 to other use, and 10 or 11 hands lines 1 and 2. Handed-over lines are always low on `drive_out`, and their key bits read 0.
- R7: `req_n` is high whenever `cs_high` is 1, even with a request pending.
- R8: Reset clears every key bit and `sleep_ack`, holds `req_n` high and stops scanning.
- R9: `sleep_ack` reports whether `sleep_code` was nonzero (1) or 00 (0) at the moment the key press woke the block.
- R10: During a scan at most one drive line is high. Slots run from line 1 upward, 64 cycles each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_in | input | 5 | Matrix sense inputs, asynchronous |
| sleep_code | input | 2 | Idle drive level selection, 00 = normal |
| share_code | input | 2 | Drive lines handed over to other use |
| cs_high | input | 1 | Serial transfer in progress, masks the request |
| rd_done | input | 1 | One-cycle pulse: key buffer has been read |
| drive_out | output | 6 | Matrix drive lines |
| req_n | output | 1 | Active-low read request |
| key_data | output | 30 | Confirmed key buffer |
| sleep_ack | output | 1 | Mode at the time of the wake-up press |

## Verification
Every cycle, the assertions check the following:
- the request masking under chip enable;
- the hold-until-read and clear-after-read behaviour of the request;
- one-hot driving during scans and the idle drive levels for each sleep and share code;
- the minimum 800-cycle distance from scan start to request.

Some behaviour only the bench scenarios can show. These are the bit mapping of real key presses and the rejection of short presses. They also include the rescan after a pattern change between the two scans, and the failure of a key on a low idle line to wake the block. The remaining ones are the captured sleep-acknowledge value and the masking of key bits on handed-over lines.

// File: rtl/kms_pkg.sv
package kms_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SCAN = 3'd1,
    ST_CMP  = 3'd2,
    ST_HOLD = 3'd3,
    ST_REQ  = 3'd4
  } kms_state_e;
endpackage

// File: rtl/kms_sync.sv
module kms_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/kms_line_drv.sv
module kms_line_drv #(
  parameter int ND = 6,
  parameter int SW = 3
) (
  input  logic [1:0]    sleep_code,
  input  logic [1:0]    share_code,
  input  logic          scanning,
  input  logic [SW-1:0] slot,
  output logic [ND-1:0] drive,
  output logic [ND-1:0] shared
);
  for (genvar i = 0; i < ND; i++) begin : g_line
    logic idle_hi;

    always_comb begin
      unique case (sleep_code)
        2'b01:   idle_hi = (i == ND - 1);
        2'b10:   idle_hi = (i >= ND - 2);
        default: idle_hi = 1'b1;
      endcase
    end

    if (i == 0) begin : g_sh0
      assign shared[i] = (share_code != 2'b00);
    end else if (i == 1) begin : g_sh1
      assign shared[i] = share_code[1];
    end else begin : g_shn
      assign shared[i] = 1'b0;
    end

    assign drive[i] = ~shared[i] & (scanning ? (slot == SW'(i)) : idle_hi);
  end
endmodule

// File: rtl/kms_ctrl.sv
module kms_ctrl
  import kms_pkg::*;
#(
  parameter int ND        = 6,
  parameter int NS        = 5,
  parameter int SCAN_LEN  = 384,
  parameter int REQ_DELAY = 800,
  parameter int SW        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS-1:0]    sense_s,
  input  logic [ND-1:0]    shared,
  input  logic [1:0]       sleep_code,
  input  logic             rd_done,
  output logic             scanning,
  output logic             in_idle,
  output logic             req_q,
  output logic [SW-1:0]    slot_q,
  output logic [ND*NS-1:0] key_buf,
  output logic             ack_q
);
  localparam int NK       = ND * NS;
  localparam int SLOT_LEN = SCAN_LEN / ND;
  localparam int CYW      = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam int CW       = $clog2(REQ_DELAY + 1);

  kms_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CYW-1:0] cyc_q, cyc_d;
  logic [SW-1:0] slot_d;
  logic          pass_q, pass_d;
  logic [NK-1:0] a_q, a_d, b_q, b_d;
  logic          ack_cap_q, ack_cap_d;
  logic          req_d;
  logic          buf_ld;
  logic [NS-1:0] row;

  // next-state process
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    cyc_d     = cyc_q;
    slot_d    = slot_q;
    pass_d    = pass_q;
    a_d       = a_q;
    b_d       = b_q;
    ack_cap_d = ack_cap_q;
    req_d     = req_q;
    buf_ld    = 1'b0;
    row       = sense_s & {NS{~shared[slot_q]}};

    unique case (st_q)
      ST_IDLE: begin
        if (|sense_s) begin
          st_d      = ST_SCAN;
          cnt_d     = '0;
          cyc_d     = '0;
          slot_d    = '0;
          pass_d    = 1'b0;
          ack_cap_d = (sleep_code != 2'b00);
        end
      end
      ST_SCAN: begin
        cnt_d = cnt_q + 1'b1;
        if (cyc_q == CYW'(SLOT_LEN - 1)) begin
          cyc_d = '0;
          if (pass_q) b_d[int'(slot_q)*NS +: NS] = row;
          else        a_d[int'(slot_q)*NS +: NS] = row;
          if (slot_q == SW'(ND - 1)) begin
            slot_d = '0;
            pass_d = 1'b1;
            if (pass_q) st_d = ST_CMP;
          end else begin
            slot_d = slot_q + 1'b1;
          end
        end else begin
          cyc_d = cyc_q + 1'b1;
        end
      end
      ST_CMP: begin
        cnt_d = cnt_q + 1'b1;
        if (a_q != b_q) begin
          st_d   = ST_SCAN;
          cnt_d  = '0;
          cyc_d  = '0;
          slot_d = '0;
          pass_d = 1'b0;
        end else if (a_q == '0) begin
          st_d = ST_IDLE;
        end else begin
          st_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(REQ_DELAY - 1)) begin
          st_d   = ST_REQ;
          buf_ld = 1'b1;
          req_d  = 1'b1;
        end
      end
      ST_REQ: begin
        if (rd_done) begin
          st_d   = ST_SCAN;
          cnt_d  = '0;
          cyc_d  = '0;
          slot_d = '0;
          pass_d = 1'b0;
          req_d  = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      cyc_q     <= '0;
      slot_q    <= '0;
      pass_q    <= 1'b0;
      a_q       <= '0;
      b_q       <= '0;
      ack_cap_q <= 1'b0;
      req_q     <= 1'b0;
      key_buf   <= '0;
      ack_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      cyc_q     <= cyc_d;
      slot_q    <= slot_d;
      pass_q    <= pass_d;
      a_q       <= a_d;
      b_q       <= b_d;
      ack_cap_q <= ack_cap_d;
      req_q     <= req_d;
      if (buf_ld) begin
        key_buf <= a_q;
        ack_q   <= ack_cap_q;
      end
    end
  end

  assign scanning = (st_q == ST_SCAN);
  assign in_idle  = (st_q == ST_IDLE);
endmodule

// File: rtl/keymat_scanner.sv
module keymat_scanner #(
  parameter int NUM_DRIVE = 6,
  parameter int NUM_SENSE = 5,
  parameter int SCAN_LEN  = 384,
  parameter int REQ_DELAY = 800
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SENSE-1:0]       sense_in,
  input  logic [1:0]                 sleep_code,
  input  logic [1:0]                 share_code,
  input  logic                       cs_high,
  input  logic                       rd_done,
  output logic [NUM_DRIVE-1:0]       drive_out,
  output logic                       req_n,
  output logic [NUM_DRIVE*NUM_SENSE-1:0] key_data,
  output logic                       sleep_ack
);
  localparam int SW = (NUM_DRIVE > 1) ? $clog2(NUM_DRIVE) : 1;

  logic [NUM_SENSE-1:0] sense_s;
  logic [NUM_DRIVE-1:0] shared_w;
  logic                 scanning_w;
  logic                 idle_w;
  logic                 req_w;
  logic [SW-1:0]        slot_w;

  kms_sync #(.W(NUM_SENSE)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sense_in),
    .q     (sense_s)
  );

  kms_line_drv #(.ND(NUM_DRIVE), .SW(SW)) drv_i (
    .sleep_code (sleep_code),
    .share_code (share_code),
    .scanning   (scanning_w),
    .slot       (slot_w),
    .drive      (drive_out),
    .shared     (shared_w)
  );

  kms_ctrl #(
    .ND        (NUM_DRIVE),
    .NS        (NUM_SENSE),
    .SCAN_LEN  (SCAN_LEN),
    .REQ_DELAY (REQ_DELAY),
    .SW        (SW)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sense_s    (sense_s),
    .shared     (shared_w),
    .sleep_code (sleep_code),
    .rd_done    (rd_done),
    .scanning   (scanning_w),
    .in_idle    (idle_w),
    .req_q      (req_w),
    .slot_q     (slot_w),
    .key_buf    (key_data),
    .ack_q      (sleep_ack)
  );

  assign req_n = ~(req_w & ~cs_high);
endmodule

// File: rtl/keymat_scanner_chk.sv
module keymat_scanner_chk #(
  parameter int ND        = 6,
  parameter int NK        = 30,
  parameter int REQ_DELAY = 800
) (
  input logic          clk,
  input logic          rst_n,
  input logic [ND-1:0] drive_out,
  input logic          req_n,
  input logic          cs_high,
  input logic          rd_done,
  input logic [1:0]    sleep_code,
  input logic [1:0]    share_code,
  input logic [NK-1:0] key_data,
  input logic          scanning,
  input logic          in_idle,
  input logic          req_q
);
  localparam int CW = $clog2(REQ_DELAY + 2);

  logic [CW-1:0] since_q;
  logic [ND-1:0] exp_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_q <= '0;
    else if (in_idle || req_q) since_q <= '0;
    else if (since_q != CW'(REQ_DELAY + 1)) since_q <= since_q + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < ND; i++) begin
      if (sleep_code == 2'b01)      exp_idle[i] = (i == ND - 1);
      else if (sleep_code == 2'b10) exp_idle[i] = (i >= ND - 2);
      else                          exp_idle[i] = 1'b1;
    end
    if (share_code != 2'b00) exp_idle[0] = 1'b0;
    if (share_code[1])       exp_idle[1] = 1'b0;
  end

  p_req_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |-> req_n);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !rd_done) |=> req_q);

  p_req_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && rd_done) |=> !req_q);

  p_buf_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && $past(req_q)) |-> $stable(key_data));

  p_onehot_scan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scanning |-> $onehot0(drive_out));

  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (drive_out == exp_idle));

  p_shared_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (share_code != 2'b00) |-> !drive_out[0]);

  p_min_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> (since_q >= CW'(REQ_DELAY)));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r8: assert (key_data == '0 && req_n);
    end
  end
endmodule

bind keymat_scanner keymat_scanner_chk #(
  .ND        (NUM_DRIVE),
  .NK        (NUM_DRIVE*NUM_SENSE),
  .REQ_DELAY (REQ_DELAY)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .drive_out  (drive_out),
  .req_n      (req_n),
  .cs_high    (cs_high),
  .rd_done    (rd_done),
  .sleep_code (sleep_code),
  .share_code (share_code),
  .key_data   (key_data),
  .scanning   (scanning_w),
  .in_idle    (idle_w),
  .req_q      (req_w)
);

// File: tb/keymat_scanner_tb_top.sv
module keymat_scanner_tb_top;
  localparam int ND = 6;
  localparam int NS = 5;
  localparam int NK = 30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] sense;
  logic [1:0]    sleep_code;
  logic [1:0]    share_code;
  logic          cs_high;
  logic          rd_done;
  logic [ND-1:0] drive_out;
  logic          req_n;
  logic [NK-1:0] key_data;
  logic          sleep_ack;
  logic [NK-1:0] keys;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  keymat_scanner dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sense_in   (sense),
    .sleep_code (sleep_code),
    .share_code (share_code),
    .cs_high    (cs_high),
    .rd_done    (rd_done),
    .drive_out  (drive_out),
    .req_n      (req_n),
    .key_data   (key_data),
    .sleep_ack  (sleep_ack)
  );

  // key matrix: a sense input is high when a pressed key connects it to a high drive line
  always_comb begin
    sense = '0;
    for (int r = 0; r < ND; r++)
      for (int c = 0; c < NS; c++)
        if (drive_out[r] && keys[r*NS+c]) sense[c] = 1'b1;
  end

  function automatic logic [NK-1:0] exp_keys(input logic [NK-1:0] k, input logic [1:0] sh);
    logic [NK-1:0] m = k;
    if (sh != 2'b00) m[4:0] = '0;
    if (sh[1])       m[9:5] = '0;
    return m;
  endfunction

  function automatic logic [ND-1:0] exp_idle(input logic [1:0] sl, input logic [1:0] sh);
    logic [ND-1:0] v;
    case (sl)
      2'b01:   v = 6'b100000;
      2'b10:   v = 6'b110000;
      default: v = 6'b111111;
    endcase
    if (sh != 2'b00) v[0] = 1'b0;
    if (sh[1])       v[1] = 1'b0;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_req(input int maxc, output int lat);
    lat = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (!req_n) begin
        lat = i;
        break;
      end
    end
  endtask

  task automatic do_read();
    @(negedge clk) rd_done = 1'b1;
    @(negedge clk) rd_done = 1'b0;
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!req_n) seen = 1;
    end
    chk(!seen, tag, {31'd0, seen}, 32'd0);
  endtask

  task automatic run_all();
    int lat;
    int cnt;
    int dummy;
    dummy = $urandom(32'd4711);
    rst_n = 1'b0; keys = '0; sleep_code = 2'b00; share_code = 2'b00;
    cs_high = 1'b0; rd_done = 1'b0;
    tick(4);
    chk(req_n == 1'b1, "R8 req_n in reset", {31'd0, req_n}, 32'd1);
    chk(key_data == '0, "R8 key_data in reset", 32'(key_data), 32'd0);
    rst_n = 1'b1;
    tick(4);
    chk(drive_out == exp_idle(2'b00, 2'b00), "R5 idle normal", 32'(drive_out), 32'(exp_idle(2'b00, 2'b00)));

    // R10 slot order and width
    keys = '0; keys[7] = 1'b1;
    cnt = 0;
    for (int i = 0; i < 50 && drive_out != 6'b000001; i++) @(negedge clk);
    while (drive_out == 6'b000001 && cnt < 200) begin cnt++; @(negedge clk); end
    chk(cnt == 64, "R10 slot length", 32'(cnt), 32'd64);
    chk(drive_out == 6'b000010, "R10 second slot line", 32'(drive_out), 32'd2);
    wait_req(2000, lat);
    chk(key_data == exp_keys(keys, 2'b00), "R1 line2 sense3", 32'(key_data), 32'(exp_keys(keys, 2'b00)));
    keys = '0; do_read(); tick(900);

    // R1 R3 R9 single key, latency
    keys = '0; keys[14] = 1'b1;
    wait_req(2000, lat);
    chk(lat >= 800 && lat <= 1700, "R3 latency window", 32'(lat), 32'd803);
    chk(key_data == 30'h4000, "R1 line3 sense5", 32'(key_data), 32'h4000);
    chk(sleep_ack == 1'b0, "R9 normal ack", {31'd0, sleep_ack}, 32'd0);

    // R7 masking
    cs_high = 1'b1; tick(2);
    chk(req_n == 1'b1, "R7 masked by cs", {31'd0, req_n}, 32'd1);
    cs_high = 1'b0; tick(1);
    chk(req_n == 1'b0, "R7 pending after cs", {31'd0, req_n}, 32'd0);

    // R4 clear and re-request while held
    tick(50);
    chk(req_n == 1'b0, "R4 hold until read", {31'd0, req_n}, 32'd0);
    do_read();
    chk(req_n == 1'b1, "R4 cleared after read", {31'd0, req_n}, 32'd1);
    wait_req(2000, lat);
    chk(lat >= 790 && lat <= 900, "R4 re-request held key", 32'(lat), 32'd800);
    keys = '0;
    do_read();
    quiet(2500, "R4 no request after release");

    // R1 random patterns
    for (int it = 0; it < 8; it++) begin
      keys = '0;
      keys[$urandom_range(29, 0)] = 1'b1;
      if ($urandom_range(1, 0) == 1) keys[$urandom_range(29, 0)] = 1'b1;
      wait_req(2000, lat);
      chk(key_data == exp_keys(keys, 2'b00), "R1 random pattern", 32'(key_data), 32'(exp_keys(keys, 2'b00)));
      keys = '0;
      do_read();
      tick(900);
    end

    // R3 short press rejected
    keys = '0; keys[0] = 1'b1;
    tick(300);
    keys = '0;
    quiet(3000, "R3 short press ignored");

    // R2 pattern changes between the two scans -> rescan
    keys = '0; keys[2] = 1'b1;
    tick(500);
    keys = '0; keys[20] = 1'b1;
    wait_req(2500, lat);
    lat = lat + 500;
    chk(lat >= 1400 && lat <= 1700, "R2 rescan latency", 32'(lat), 32'd1572);
    chk(key_data == 30'h100000, "R2 final pattern", 32'(key_data), 32'h100000);
    keys = '0; do_read(); tick(900);

    // R5 R9 sleep modes
    sleep_code = 2'b10; tick(2);
    chk(drive_out == 6'b110000, "R5 idle code10", 32'(drive_out), 32'h30);
    sleep_code = 2'b11; tick(2);
    chk(drive_out == 6'b111111, "R5 idle code11", 32'(drive_out), 32'h3f);
    sleep_code = 2'b01; tick(2);
    chk(drive_out == 6'b100000, "R5 idle code01", 32'(drive_out), 32'h20);
    keys = '0; keys[1] = 1'b1;
    quiet(3000, "R5 low line cannot wake");
    keys[25] = 1'b1;
    wait_req(2000, lat);
    chk(key_data == 30'h2000002, "R5 wake then full scan", 32'(key_data), 32'h2000002);
    chk(sleep_ack == 1'b1, "R9 sleep ack", {31'd0, sleep_ack}, 32'd1);
    keys = '0; do_read(); tick(900);
    sleep_code = 2'b00;

    // R6 shared lines
    share_code = 2'b01; tick(2);
    chk(drive_out == 6'b111110, "R6 share01 idle", 32'(drive_out), 32'h3e);
    share_code = 2'b10; tick(2);
    chk(drive_out == 6'b111100, "R6 share10 idle", 32'(drive_out), 32'h3c);
    keys = '0; keys[3] = 1'b1; keys[17] = 1'b1;
    wait_req(2000, lat);
    chk(key_data == 30'h20000, "R6 shared bits zero", 32'(key_data), 32'h20000);

    // R8 reset with request pending
    keys = '0;
    @(negedge clk) rst_n = 1'b0;
    tick(2);
    chk(key_data == '0, "R8 reset clears keys", 32'(key_data), 32'd0);
    chk(req_n == 1'b1, "R8 reset clears request", {31'd0, req_n}, 32'd1);
    chk(sleep_ack == 1'b0, "R8 reset clears ack", {31'd0, sleep_ack}, 32'd0);
    rst_n = 1'b1;
    share_code = 2'b00;
    tick(5);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule